// File: doc/BRIEF.md
# Dynamic Loss Scale Controller

This block holds the loss scaling factor of a mixed-precision training loop as a power-of-two exponent. The scale begins at a large value. At the end of every training step the host pulses a step strobe together with an external overflow flag. The block merges that flag with its own record of any non-finite gradient seen during the step. If the step overflowed, the exponent drops by one and the step is marked for skipping. If the step was clean, it is marked for applying. After a run of clean steps of programmable length, the exponent rises by one.

The same gradient stream also passes through an unscale path. Each bfloat16 value has the scale exponent subtracted from its exponent field, so the optimizer receives the true magnitude. A value whose result would drop out of the normal range becomes a zero with the sign kept. An Inf or NaN passes through unchanged and is flagged.

The step logic is a five-state machine:
- `ST_RUN` waits for the strobe and goes to `ST_JUDGE` when it arrives.
- `ST_JUDGE` inspects the latched overflow result. It moves to `ST_BACKOFF` on overflow, to `ST_GROW` when the clean-step run completes, and to `ST_KEEP` otherwise.
- Each of `ST_BACKOFF`, `ST_KEEP` and `ST_GROW` applies its update, posts the decision and returns to `ST_RUN`.

Top module: `ls_scale_ctrl`

## Requirements
- R1: After reset, `scale_exp` equals `INIT_EXP`, the clean-step count is zero, and `dec_valid`, `dec_apply`, `dec_skip` and `unsc_valid` are all 0.
- R2: A step judged as overflowed produces `dec_skip`=1 and `dec_apply`=0. It lowers `scale_exp` by one and restarts the clean-step count from zero.
- R3: A clean step produces `dec_apply`=1 and `dec_skip`=0. On the `GROW_STEPS`-th consecutive clean step, `scale_exp` rises by one and the count restarts. Any other clean step leaves `scale_exp` unchanged.
- R4: `scale_exp` saturates. It never falls below 0 and never rises above `MAX_EXP`. A backoff at 0 or a growth at `MAX_EXP` leaves it unchanged, but still resets the count and still posts the decision.
- R5: A gradient whose exponent field (bits 14:7) is 0xFF marks the current step as overflowed. This includes a gradient accepted in the same cycle as the accepted strobe. The mark is cleared when a strobe is accepted. `step_ovf` asserted with the strobe also marks the step.
- R6: A strobe sampled in `ST_RUN` is accepted. The decision and the updated `scale_exp` appear two clock edges later, and `dec_valid` is high for exactly one cycle. A strobe sampled during the two busy cycles is ignored, and the overflow mark is kept for the next step.
- R7: For a gradient with exponent field e, where 0 < e < 0xFF and e > `scale_exp`, `unsc_out` keeps the sign (bit 15) and mantissa (bits 6:0), and carries exponent e − `scale_exp`. It is valid one edge after `grad_valid`, with `unsc_ovf`=0.
- R8: A gradient with e ≤ `scale_exp` (e nonzero), or a subnormal (e = 0 and nonzero mantissa), produces a zero that keeps the input sign (0x0000 or 0x8000). Both signed zeros pass unchanged.
- R9: A gradient with e = 0xFF (Inf or NaN) leaves the unscale path bit-for-bit unchanged, with `unsc_ovf`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| grad_valid | input | 1 | A gradient value is present on `grad_in` |
| grad_in | input | 16 | bfloat16 gradient, scaled |
| step_done | input | 1 | End-of-step strobe |
| step_ovf | input | 1 | External overflow flag for the step, sampled with `step_done` |
| scale_exp | output | EXP_W | Current scale exponent; scale = 2^scale_exp |
| dec_valid | output | 1 | Step decision valid, one cycle |
| dec_apply | output | 1 | The optimizer shall apply the step |
| dec_skip | output | 1 | The optimizer shall discard the step |
| unsc_valid | output | 1 | `unsc_out` holds an unscaled value |
| unsc_out | output | 16 | Unscaled bfloat16 gradient |
| unsc_ovf | output | 1 | The unscaled value is Inf or NaN |

## Verification
Each unscaled gradient is due one edge after it is presented, and is computed with the exponent that held at that edge. A step decision and its new exponent are due two edges after the accepted strobe, and the decision flag must drop again one edge later. The bench drives on falling edges and counts falling edges to land each sample half a period after the edge that should produce the result. It tracks the scale, the clean-step run and the overflow mark in its own model. Gradients and strobes are never placed where that model and the required timing would disagree.

// File: rtl/ls_pkg.sv
package ls_pkg;

    typedef enum logic [2:0] {
        ST_RUN     = 3'd0,
        ST_JUDGE   = 3'd1,
        ST_BACKOFF = 3'd2,
        ST_KEEP    = 3'd3,
        ST_GROW    = 3'd4
    } step_state_t;

    typedef struct packed {
        logic       sgn;
        logic [7:0] ex;
        logic [6:0] man;
    } bf16_t;

    localparam logic [7:0] BF16_EXP_SPECIAL = 8'hFF;

    function automatic logic bf16_nonfinite(input bf16_t v);
        return v.ex == BF16_EXP_SPECIAL;
    endfunction

endpackage

// File: rtl/ls_ovf_sticky.sv
module ls_ovf_sticky
    import ls_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        grad_valid,
    input  logic [15:0] grad_in,
    input  logic        step_flag,
    input  logic        clear,
    output logic        step_ovf_now
);

    logic mark_q;
    logic hit;

    always_comb begin
        hit          = grad_valid && bf16_nonfinite(bf16_t'(grad_in));
        step_ovf_now = mark_q || hit || step_flag;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mark_q <= 1'b0;
        end else if (clear) begin
            mark_q <= 1'b0;
        end else if (hit) begin
            mark_q <= 1'b1;
        end
    end

endmodule

// File: rtl/ls_unscale.sv
module ls_unscale
    import ls_pkg::*;
#(
    parameter int EXP_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [15:0]      in_data,
    input  logic [EXP_W-1:0] scale_exp,
    output logic             out_valid,
    output logic [15:0]      out_data,
    output logic             out_ovf
);

    bf16_t      src;
    bf16_t      res;
    logic       res_ovf;
    logic [7:0] sc8;

    always_comb begin
        src     = bf16_t'(in_data);
        sc8     = 8'(scale_exp);
        res     = src;
        res_ovf = 1'b0;
        if (bf16_nonfinite(src)) begin
            res_ovf = 1'b1;
        end else if (src.ex == 8'd0) begin
            res = '{sgn: src.sgn, ex: 8'd0, man: 7'd0};
        end else if (src.ex <= sc8) begin
            res = '{sgn: src.sgn, ex: 8'd0, man: 7'd0};
        end else begin
            res.ex = src.ex - sc8;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= 16'd0;
            out_ovf   <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_data <= 16'(res);
                out_ovf  <= res_ovf;
            end
        end
    end

endmodule

// File: rtl/ls_step_fsm.sv
module ls_step_fsm
    import ls_pkg::*;
#(
    parameter int INIT_EXP   = 16,
    parameter int MAX_EXP    = 24,
    parameter int GROW_STEPS = 2000,
    parameter int EXP_W      = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step_done,
    input  logic             step_ovf_now,
    output logic             accept,
    output logic [EXP_W-1:0] scale_exp,
    output logic             dec_valid,
    output logic             dec_apply,
    output logic             dec_skip
);

    localparam int CNT_W = $clog2(GROW_STEPS + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(GROW_STEPS - 1);
    localparam logic [EXP_W-1:0] EXP_TOP  = EXP_W'(MAX_EXP);
    localparam logic [EXP_W-1:0] EXP_INIT = EXP_W'(INIT_EXP);

    step_state_t      state_q, state_d;
    logic             ovf_q;
    logic [CNT_W-1:0] cnt_q;

    assign accept = (state_q == ST_RUN) && step_done;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_RUN;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN:     state_d = step_done ? ST_JUDGE : ST_RUN;
            ST_JUDGE: begin
                if (ovf_q) begin
                    state_d = ST_BACKOFF;
                end else if (cnt_q == CNT_LAST) begin
                    state_d = ST_GROW;
                end else begin
                    state_d = ST_KEEP;
                end
            end
            ST_BACKOFF: state_d = ST_RUN;
            ST_KEEP:    state_d = ST_RUN;
            ST_GROW:    state_d = ST_RUN;
            default:    state_d = ST_RUN;
        endcase
    end

    // outputs and datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovf_q     <= 1'b0;
            cnt_q     <= '0;
            scale_exp <= EXP_INIT;
            dec_valid <= 1'b0;
            dec_apply <= 1'b0;
            dec_skip  <= 1'b0;
        end else begin
            dec_valid <= 1'b0;
            dec_apply <= 1'b0;
            dec_skip  <= 1'b0;
            if (accept) begin
                ovf_q <= step_ovf_now;
            end
            unique case (state_q)
                ST_BACKOFF: begin
                    if (scale_exp != '0) begin
                        scale_exp <= scale_exp - EXP_W'(1);
                    end
                    cnt_q     <= '0;
                    dec_valid <= 1'b1;
                    dec_skip  <= 1'b1;
                end
                ST_KEEP: begin
                    cnt_q     <= cnt_q + CNT_W'(1);
                    dec_valid <= 1'b1;
                    dec_apply <= 1'b1;
                end
                ST_GROW: begin
                    if (scale_exp != EXP_TOP) begin
                        scale_exp <= scale_exp + EXP_W'(1);
                    end
                    cnt_q     <= '0;
                    dec_valid <= 1'b1;
                    dec_apply <= 1'b1;
                end
                default: begin
                end
            endcase
        end
    end

endmodule

// File: rtl/ls_scale_ctrl.sv
module ls_scale_ctrl
    import ls_pkg::*;
#(
    parameter int INIT_EXP   = 16,
    parameter int MAX_EXP    = 24,
    parameter int GROW_STEPS = 2000,
    parameter int EXP_W      = $clog2(MAX_EXP + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             grad_valid,
    input  logic [15:0]      grad_in,
    input  logic             step_done,
    input  logic             step_ovf,
    output logic [EXP_W-1:0] scale_exp,
    output logic             dec_valid,
    output logic             dec_apply,
    output logic             dec_skip,
    output logic             unsc_valid,
    output logic [15:0]      unsc_out,
    output logic             unsc_ovf
);

    logic accept;
    logic step_ovf_now;

    ls_ovf_sticky u_sticky (
        .clk          (clk),
        .rst_n        (rst_n),
        .grad_valid   (grad_valid),
        .grad_in      (grad_in),
        .step_flag    (step_ovf),
        .clear        (accept),
        .step_ovf_now (step_ovf_now)
    );

    ls_step_fsm #(
        .INIT_EXP   (INIT_EXP),
        .MAX_EXP    (MAX_EXP),
        .GROW_STEPS (GROW_STEPS),
        .EXP_W      (EXP_W)
    ) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .step_done    (step_done),
        .step_ovf_now (step_ovf_now),
        .accept       (accept),
        .scale_exp    (scale_exp),
        .dec_valid    (dec_valid),
        .dec_apply    (dec_apply),
        .dec_skip     (dec_skip)
    );

    ls_unscale #(
        .EXP_W (EXP_W)
    ) u_unscale (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (grad_valid),
        .in_data   (grad_in),
        .scale_exp (scale_exp),
        .out_valid (unsc_valid),
        .out_data  (unsc_out),
        .out_ovf   (unsc_ovf)
    );

endmodule

// File: rtl/ls_scale_chk.sv
module ls_scale_chk #(
    parameter int MAX_EXP = 24,
    parameter int EXP_W   = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic [EXP_W-1:0] scale_exp,
    input logic             dec_valid,
    input logic             dec_apply,
    input logic             dec_skip,
    input logic             unsc_valid,
    input logic [15:0]      unsc_out,
    input logic             unsc_ovf
);

    a_r4_exp_range: assert property (@(posedge clk) disable iff (!rst_n)
        scale_exp <= EXP_W'(MAX_EXP));

    a_r6_exp_steady: assert property (@(posedge clk) disable iff (!rst_n)
        !dec_valid |-> $stable(scale_exp));

    a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid |=> !dec_valid);

    a_r2_verdict_excl: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid |-> (dec_apply != dec_skip));

    a_r2_quiet_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !dec_valid |-> (!dec_apply && !dec_skip));

    a_r2_skip_lowers: assert property (@(posedge clk) disable iff (!rst_n)
        dec_skip |-> (($past(scale_exp) == '0) ? (scale_exp == '0)
                                               : (scale_exp == $past(scale_exp) - EXP_W'(1))));

    a_r3_apply_no_drop: assert property (@(posedge clk) disable iff (!rst_n)
        dec_apply |-> ((scale_exp == $past(scale_exp)) ||
                       (scale_exp == $past(scale_exp) + EXP_W'(1))));

    a_r9_ovf_special: assert property (@(posedge clk) disable iff (!rst_n)
        (unsc_valid && unsc_ovf) |-> (unsc_out[14:7] == 8'hFF));

    a_r7_finite_stays_finite: assert property (@(posedge clk) disable iff (!rst_n)
        (unsc_valid && !unsc_ovf) |-> (unsc_out[14:7] != 8'hFF));

endmodule

bind ls_scale_ctrl ls_scale_chk #(
    .MAX_EXP (MAX_EXP),
    .EXP_W   (EXP_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .scale_exp  (scale_exp),
    .dec_valid  (dec_valid),
    .dec_apply  (dec_apply),
    .dec_skip   (dec_skip),
    .unsc_valid (unsc_valid),
    .unsc_out   (unsc_out),
    .unsc_ovf   (unsc_ovf)
);

// File: tb/ls_scale_ctrl_bench.sv
`timescale 1ns/1ps
module ls_scale_ctrl_bench;

    localparam int INIT_EXP   = 16;
    localparam int MAX_EXP    = 18;
    localparam int GROW_STEPS = 4;
    localparam int EXP_W      = $clog2(MAX_EXP + 1);

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             grad_valid = 1'b0;
    logic [15:0]      grad_in = 16'd0;
    logic             step_done = 1'b0;
    logic             step_ovf = 1'b0;
    logic [EXP_W-1:0] scale_exp;
    logic             dec_valid, dec_apply, dec_skip;
    logic             unsc_valid, unsc_ovf;
    logic [15:0]      unsc_out;

    int errors = 0;
    int checks = 0;
    int m_exp  = INIT_EXP;
    int m_cnt  = 0;
    bit m_mark = 0;

    always #4 clk = ~clk;

    ls_scale_ctrl #(
        .INIT_EXP   (INIT_EXP),
        .MAX_EXP    (MAX_EXP),
        .GROW_STEPS (GROW_STEPS)
    ) u_ls_scale_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .grad_valid (grad_valid),
        .grad_in    (grad_in),
        .step_done  (step_done),
        .step_ovf   (step_ovf),
        .scale_exp  (scale_exp),
        .dec_valid  (dec_valid),
        .dec_apply  (dec_apply),
        .dec_skip   (dec_skip),
        .unsc_valid (unsc_valid),
        .unsc_out   (unsc_out),
        .unsc_ovf   (unsc_ovf)
    );

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, expv);
        end
    endtask

    function automatic logic [15:0] exp_unscale(input logic [15:0] g, input int e);
        int ex = int'(g[14:7]);
        if (ex == 255) return g;
        if (ex == 0) return {g[15], 15'd0};
        if (ex <= e) return {g[15], 15'd0};
        return {g[15], 8'(ex - e), g[6:0]};
    endfunction

    function automatic bit is_special(input logic [15:0] g);
        return g[14:7] == 8'hFF;
    endfunction

    // model update for one judged step; returns 1 when skipped
    function automatic bit model_step(input bit ovf);
        if (ovf) begin
            if (m_exp > 0) m_exp--;
            m_cnt = 0;
            return 1'b1;
        end
        if (m_cnt == GROW_STEPS - 1) begin
            if (m_exp < MAX_EXP) m_exp++;
            m_cnt = 0;
        end else begin
            m_cnt++;
        end
        return 1'b0;
    endfunction

    task automatic send_grad(input logic [15:0] g, input string req);
        logic [15:0] e;
        @(negedge clk);
        grad_valid = 1'b1;
        grad_in    = g;
        e = exp_unscale(g, m_exp);
        if (is_special(g)) m_mark = 1;
        @(negedge clk);
        grad_valid = 1'b0;
        chk(unsc_valid == 1'b1, req, int'(unsc_valid), 1);
        chk(unsc_out == e, req, int'(unsc_out), int'(e));
        chk(unsc_ovf == is_special(g), req, int'(unsc_ovf), int'(is_special(g)));
    endtask

    // hold: number of cycles step_done stays high (1 normal, 3 for busy test)
    task automatic run_step(input bit flag, input bit with_grad, input logic [15:0] g,
                            input int hold, input string req);
        bit skip;
        bit ovf;
        @(negedge clk);
        step_done = 1'b1;
        step_ovf  = flag;
        if (with_grad) begin
            grad_valid = 1'b1;
            grad_in    = g;
        end
        ovf = flag || m_mark || (with_grad && is_special(g));
        m_mark = 0;
        @(negedge clk);
        grad_valid = 1'b0;
        if (hold == 1) begin
            step_done = 1'b0;
            step_ovf  = 1'b0;
        end
        chk(dec_valid == 1'b0, "R6", int'(dec_valid), 0);
        @(negedge clk);
        chk(dec_valid == 1'b0, "R6", int'(dec_valid), 0);
        @(negedge clk);
        step_done = 1'b0;
        step_ovf  = 1'b0;
        skip = model_step(ovf);
        chk(dec_valid == 1'b1, "R6", int'(dec_valid), 1);
        chk(dec_skip == skip, req, int'(dec_skip), int'(skip));
        chk(dec_apply == !skip, req, int'(dec_apply), int'(!skip));
        chk(int'(scale_exp) == m_exp, req, int'(scale_exp), m_exp);
        @(negedge clk);
        chk(dec_valid == 1'b0, "R6", int'(dec_valid), 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int seed_dummy;
        seed_dummy = $urandom(32'h5EED_0C1E);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(int'(scale_exp) == INIT_EXP, "R1", int'(scale_exp), INIT_EXP);
        chk(dec_valid == 0 && dec_apply == 0 && dec_skip == 0, "R1",
            int'({dec_valid, dec_apply, dec_skip}), 0);
        chk(unsc_valid == 1'b0, "R1", int'(unsc_valid), 0);

        // R3 growth after GROW_STEPS clean steps, then R4 ceiling
        for (int i = 0; i < 3 * GROW_STEPS; i++) run_step(0, 0, 16'd0, 1, "R3");
        chk(int'(scale_exp) == MAX_EXP, "R4", int'(scale_exp), MAX_EXP);

        // R2 backoff through external flag
        run_step(1, 0, 16'd0, 1, "R2");
        // R2 counter restart: 3 clean, overflow, 3 clean -> no growth
        for (int i = 0; i < GROW_STEPS - 1; i++) run_step(0, 0, 16'd0, 1, "R3");
        send_grad(16'h7F80, "R9");
        run_step(0, 0, 16'd0, 1, "R5");
        for (int i = 0; i < GROW_STEPS - 1; i++) run_step(0, 0, 16'd0, 1, "R2");
        run_step(0, 0, 16'd0, 1, "R3");

        // R5 special gradient in same cycle as strobe
        run_step(0, 1, 16'hFFC1, 1, "R5");
        // R5 mark cleared after acceptance: next step clean
        run_step(0, 0, 16'd0, 1, "R5");

        // R6 strobe held through busy cycles: single decision
        run_step(0, 0, 16'd0, 3, "R6");
        repeat (2) begin
            @(negedge clk);
            chk(dec_valid == 1'b0, "R6", int'(dec_valid), 0);
        end
        chk(int'(scale_exp) == m_exp, "R6", int'(scale_exp), m_exp);

        // R7 / R8 / R9 directed unscale
        send_grad(16'h3F80, "R7");
        send_grad(16'hC2A5, "R7");
        send_grad({1'b0, 8'(m_exp), 7'h33}, "R8");
        send_grad({1'b1, 8'(m_exp), 7'h33}, "R8");
        send_grad(16'h0000, "R8");
        send_grad(16'h8000, "R8");
        send_grad(16'h0001, "R8");
        send_grad(16'h8042, "R8");
        send_grad(16'h7FC0, "R9");

        // R4 floor: drive exponent down to 0 and past it
        for (int i = 0; i < MAX_EXP + 3; i++) run_step(1, 0, 16'd0, 1, "R4");
        chk(int'(scale_exp) == 0, "R4", int'(scale_exp), 0);
        send_grad(16'h0080, "R7");
        send_grad(16'hBF80, "R7");

        // constrained random
        for (int it = 0; it < 80; it++) begin
            int n = int'($urandom_range(0, 3));
            for (int k = 0; k < n; k++) begin
                logic [15:0] g;
                int pick = int'($urandom_range(0, 7));
                g = 16'($urandom);
                if (pick == 0) g[14:7] = 8'hFF;
                else if (pick == 1) g[14:7] = 8'($urandom_range(0, 20));
                send_grad(g, "R7");
            end
            run_step(($urandom_range(0, 5) == 0), 0, 16'd0, 1, "R3");
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule